// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block observes the clock and data wires of a two-wire serial bus whose levels have already been synchronised into the local clock domain. It recognises the two bus framing conditions. A start is the data wire falling while the clock wire is high. A stop is the data wire rising while the clock wire is high. The block keeps one sticky history bit for each of them, and it derives from that history whether a new master may claim the bus.

The block also owns the interrupt source of the serial port it sits beside. A start, a stop, or a byte-complete strobe from the neighbouring shift logic raises an event. Each event produces a single-cycle pulse and sets a sticky flag. The flag stays set until software pulses a clear input. A separate enable input gates the flag onto the interrupt output. When the monitor enable is low, all history and the flag are cleared, and no event is recorded.

Top module: `i2c_bus_watch`

## Requirements
- R1: After a synchronous active-low reset, `start_seen`, `stop_seen`, `irq_flag`, `evt_o` and `irq_o` are 0 and `bus_free` is 1.
- R2: An SDA transition from 1 to 0 while SCL is 1 in both the old and the new sample is a start. Two clock edges after the new levels are applied, `start_seen` is 1 and `stop_seen` is 0.
- R3: An SDA transition from 0 to 1 while SCL is 1 in both the old and the new sample is a stop. Two clock edges later, `stop_seen` is 1 and `start_seen` is 0.
- R4: An SDA transition with SCL low in either sample, and any SCL transition with SDA unchanged, leave `start_seen`, `stop_seen` and `irq_flag` unchanged.
- R5: `bus_free` is 1 exactly when `stop_seen` is 1 or both history bits are 0.
- R6: While `mon_en` is 0, the history bits and `irq_flag` are 0 one edge later. Starts, stops and `byte_done` have no effect during that time.
- R7: Each start, stop or `byte_done` seen while enabled sets `irq_flag` and raises `evt_o` for exactly one cycle. For `byte_done`, both happen one edge after the strobe is sampled.
- R8: `irq_flag` stays set until `irq_clr` is sampled 1. If a new event arrives in the same cycle as `irq_clr`, the flag stays set.
- R9: `irq_o` is `irq_flag` gated by `irq_en`. If `irq_en` is turned on while the bus is busy and the flag is clear, `irq_o` next rises at the stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_en | input | 1 | Monitor enable; low clears all status |
| scl_i | input | 1 | Synchronised clock wire level |
| sda_i | input | 1 | Synchronised data wire level |
| byte_done | input | 1 | One-cycle strobe from the shift logic at the end of each byte |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| start_seen | output | 1 | Sticky: last condition seen was a start |
| stop_seen | output | 1 | Sticky: last condition seen was a stop |
| bus_free | output | 1 | Bus may be claimed by a new master |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt_o | output | 1 | One-cycle pulse per recorded event |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bench sweeps every pair of old and new wire levels. This exposes a detector that qualifies SCL on only one sample, or that mistakes data-bit changes under a low clock for framing. Such a detector would set a history bit in the middle of a byte and report the bus as taken or free at the wrong moment. Further directed cases target the collision between a clear and a new event, which a clear-priority flag would lose silently. They also cover enabling the interrupt in the middle of a transfer, where a design that latched the earlier start would fire at once instead of waiting for the stop. Finally, they show that disabling really forgets the history, so that a monitor re-enabled on a quiet bus reports it free.

// File: rtl/i2c_mon_pkg.sv
// Package: types and event indices shared by the bus monitor modules.
// Assumes: wire levels are already in the local clock domain.
package i2c_mon_pkg;

    // Snapshot of both bus wires at one sampling edge.
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    // Level of an idle, pulled-up bus.
    localparam line_t LINE_IDLE = '{scl: 1'b1, sda: 1'b1};

    // Interrupt event sources; the order only selects the bit in the event vector.
    typedef enum int unsigned {
        EV_START = 0,
        EV_STOP  = 1,
        EV_BYTE  = 2
    } ev_idx_e;

    localparam int unsigned NUM_EV = 3;

endpackage

// File: rtl/i2c_line_sampler.sv
// Module: i2c_line_sampler
// Keeps a short history of the bus wire levels so that the condition detector
// can compare the newest sample with the one before it.
// Assumes: inputs are already synchronised. The history resets to the idle
// level, so a quiet bus produces no condition after reset.
module i2c_line_sampler
    import i2c_mon_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_t line_in,
    output line_t cur,
    output line_t prev
);

    line_t hist [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                // Capture the incoming wire levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) hist[g] <= LINE_IDLE;
                    else        hist[g] <= line_in;
                end
            end else begin : g_tail
                // Age the sample by one more cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) hist[g] <= LINE_IDLE;
                    else        hist[g] <= hist[g-1];
                end
            end
        end
    endgenerate

    assign cur  = hist[0];
    assign prev = hist[1];

endmodule

// File: rtl/i2c_cond_detect.sv
// Module: i2c_cond_detect
// Decodes start and stop from two consecutive samples. The clock wire must be
// high in both samples, so data-bit changes under a low clock, and changes
// that coincide with a clock edge, are not framing.
// Assumes: the samples come from i2c_line_sampler.
module i2c_cond_detect
    import i2c_mon_pkg::*;
(
    input  line_t cur,
    input  line_t prev,
    output logic  start_det,
    output logic  stop_det
);

    logic clk_held_high;

    // Qualify on a clock wire that stayed high across the sample pair.
    always_comb begin
        clk_held_high = cur.scl & prev.scl;
        start_det     = clk_held_high &  prev.sda & ~cur.sda;
        stop_det      = clk_held_high & ~prev.sda &  cur.sda;
    end

endmodule

// File: rtl/i2c_bus_state.sv
// Module: i2c_bus_state
// Holds the sticky start and stop history and derives bus ownership from it.
// Each condition sets its own bit and clears the other one. Disable and reset
// clear both bits.
// Assumes: start and stop never arrive in the same cycle.
module i2c_bus_state (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_det,
    input  logic stop_det,
    output logic s_bit,
    output logic p_bit,
    output logic free
);

    // Track the most recent framing condition.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            s_bit <= 1'b0;
            p_bit <= 1'b0;
        end else if (start_det) begin
            s_bit <= 1'b1;
            p_bit <= 1'b0;
        end else if (stop_det) begin
            s_bit <= 1'b0;
            p_bit <= 1'b1;
        end
    end

    // The bus is free after a stop, or when no condition has been seen since reset or disable.
    always_comb begin
        free = p_bit | (~s_bit & ~p_bit);
    end

endmodule

// File: rtl/i2c_irq_ctrl.sv
// Module: i2c_irq_ctrl
// Merges the event sources into a one-cycle pulse and a sticky flag. A new
// event takes priority over a clear in the same cycle, so no event is lost.
// The request output is the flag gated by its enable.
// Assumes: sources are single-cycle strobes.
module i2c_irq_ctrl #(
    parameter int unsigned N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [N_SRC-1:0] src,
    input  logic             clr,
    input  logic             irq_en,
    output logic             flag,
    output logic             pulse,
    output logic             req
);

    logic [N_SRC-1:0] src_q;
    logic             any_ev;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            // Mask each source while the monitor is disabled.
            always_comb src_q[g] = src[g] & enable;
        end
    endgenerate

    // Reduce the masked sources to a single hit.
    always_comb any_ev = |src_q;

    // Register the single-cycle event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= any_ev;
    end

    // Sticky flag: set wins over clear; disable forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) flag <= 1'b0;
        else if (any_ev)       flag <= 1'b1;
        else if (clr)          flag <= 1'b0;
    end

    // Gate the flag onto the request output.
    always_comb req = flag & irq_en;

endmodule

// File: rtl/i2c_bus_watch.sv
// Module: i2c_bus_watch (top)
// Start/stop monitor for a multi-master two-wire bus: keeps the sticky condition
// history, reports whether the bus may be claimed, and raises interrupts on
// framing conditions and on byte completion.
// Assumes: scl_i/sda_i are synchronised; byte_done is a one-cycle strobe.
module i2c_bus_watch
    import i2c_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic scl_i,
    input  logic sda_i,
    input  logic byte_done,
    input  logic irq_en,
    input  logic irq_clr,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq_flag,
    output logic evt_o,
    output logic irq_o
);

    line_t            line_now;
    line_t            s_cur;
    line_t            s_prev;
    logic             start_det;
    logic             stop_det;
    logic [NUM_EV-1:0] ev_vec;

    // Pack the wire levels into one sample.
    always_comb begin
        line_now.scl = scl_i;
        line_now.sda = sda_i;
    end

    i2c_line_sampler #(.DEPTH(2)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_now),
        .cur     (s_cur),
        .prev    (s_prev)
    );

    i2c_cond_detect u_det (
        .cur       (s_cur),
        .prev      (s_prev),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bus_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mon_en),
        .start_det (start_det),
        .stop_det  (stop_det),
        .s_bit     (start_seen),
        .p_bit     (stop_seen),
        .free      (bus_free)
    );

    // Build the event vector by source index.
    always_comb begin
        ev_vec           = '0;
        ev_vec[EV_START] = start_det;
        ev_vec[EV_STOP]  = stop_det;
        ev_vec[EV_BYTE]  = byte_done;
    end

    i2c_irq_ctrl #(.N_SRC(NUM_EV)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mon_en),
        .src    (ev_vec),
        .clr    (irq_clr),
        .irq_en (irq_en),
        .flag   (irq_flag),
        .pulse  (evt_o),
        .req    (irq_o)
    );

endmodule

// File: rtl/i2c_bus_watch_chk.sv
// Module: i2c_bus_watch_chk
// Property checker attached to every i2c_bus_watch instance by the bind below.
// Assumes: it only observes the top-level ports.
module i2c_bus_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic mon_en,
    input logic byte_done,
    input logic irq_en,
    input logic irq_clr,
    input logic start_seen,
    input logic stop_seen,
    input logic bus_free,
    input logic irq_flag,
    input logic evt_o,
    input logic irq_o
);

    // R2/R3: at most one history bit is set at a time
    p_hist_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_seen, stop_seen}));

    // R2: a newly recorded start is reported as a busy bus and raises the flag
    p_start_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_seen) |-> (irq_flag && !bus_free));

    // R3: a newly recorded stop frees the bus and raises the flag
    p_stop_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> (irq_flag && bus_free));

    // R6: disable clears everything on the next edge
    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!start_seen && !stop_seen && !irq_flag));

    // R7: byte completion while enabled sets the flag and pulses
    p_byte_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && mon_en) |=> (irq_flag && evt_o));

    // R7: the flag only rises together with an event pulse
    p_flag_rise_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> evt_o);

    // R8: the flag holds while no clear is requested
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr && mon_en) |=> irq_flag);

    // R9: no request without the enable
    p_req_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);

endmodule

bind i2c_bus_watch i2c_bus_watch_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_en     (mon_en),
    .byte_done  (byte_done),
    .irq_en     (irq_en),
    .irq_clr    (irq_clr),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .bus_free   (bus_free),
    .irq_flag   (irq_flag),
    .evt_o      (evt_o),
    .irq_o      (irq_o)
);

// File: tb/i2c_bus_watch_tb_top.sv
// Bench for i2c_bus_watch: sweeps every wire-level transition, then runs directed
// cases on interrupts and disable. Inputs change at falling edges and outputs
// are sampled at falling edges.
module i2c_bus_watch_tb_top;

    logic clk = 1'b0;
    logic rst_n, mon_en, scl_i, sda_i, byte_done, irq_en, irq_clr;
    logic start_seen, stop_seen, bus_free, irq_flag, evt_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    i2c_bus_watch dut_i (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .scl_i(scl_i), .sda_i(sda_i),
        .byte_done(byte_done), .irq_en(irq_en), .irq_clr(irq_clr),
        .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
        .irq_flag(irq_flag), .evt_o(evt_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mon_en = 1'b1; scl_i = 1'b1; sda_i = 1'b1;
        byte_done = 1'b0; irq_en = 1'b0; irq_clr = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(3);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; step(1); irq_clr = 1'b0; step(1);
    endtask

    task automatic set_lines(input logic c, input logic d);
        scl_i = c; sda_i = d; step(2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1: reset state
        chk("R1", "start_seen", start_seen, 1'b0);
        chk("R1", "stop_seen",  stop_seen,  1'b0);
        chk("R1", "irq_flag",   irq_flag,   1'b0);
        chk("R1", "evt_o",      evt_o,      1'b0);
        chk("R1", "irq_o",      irq_o,      1'b0);
        chk("R1", "bus_free",   bus_free,   1'b1);

        // R2 R3 R4 R5: all old->new level pairs, starting from the idle bus
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic oc, od, nc, nd, s_e, p_e, st, sp;
                oc = a[1]; od = a[0]; nc = b[1]; nd = b[0];
                do_reset();
                set_lines(oc, od);
                step(1);
                // the move from idle to the old level is a start only if the clock stays high and the data falls
                s_e = oc & ~od;
                p_e = 1'b0;
                pulse_clr();
                set_lines(nc, nd);
                st = oc & nc & od & ~nd;
                sp = oc & nc & ~od & nd;
                if (st) begin s_e = 1'b1; p_e = 1'b0; end
                if (sp) begin s_e = 1'b0; p_e = 1'b1; end
                chk(st ? "R2" : (sp ? "R3" : "R4"), "start_seen", start_seen, s_e);
                chk(st ? "R2" : (sp ? "R3" : "R4"), "stop_seen",  stop_seen,  p_e);
                chk(st | sp ? "R7" : "R4", "irq_flag", irq_flag, st | sp);
                chk("R5", "bus_free", bus_free, p_e | (~s_e & ~p_e));
            end
        end

        // R7: byte strobe sets flag and a single-cycle pulse
        do_reset();
        byte_done = 1'b1; step(1); byte_done = 1'b0;
        chk("R7", "flag after byte", irq_flag, 1'b1);
        chk("R7", "pulse after byte", evt_o, 1'b1);
        step(1);
        chk("R7", "pulse one cycle", evt_o, 1'b0);
        chk("R8", "flag sticky", irq_flag, 1'b1);
        step(5);
        chk("R8", "flag still sticky", irq_flag, 1'b1);
        pulse_clr();
        chk("R8", "flag cleared", irq_flag, 1'b0);

        // R8: event in the same cycle as clear keeps the flag
        byte_done = 1'b1; irq_clr = 1'b1; step(1);
        byte_done = 1'b0; irq_clr = 1'b0;
        chk("R8", "set beats clear", irq_flag, 1'b1);

        // R9: interrupt enabled mid-transfer fires at the stop
        do_reset();
        set_lines(1'b1, 1'b0);                 // start
        chk("R9", "no req while disabled", irq_o, 1'b0);
        pulse_clr();
        irq_en = 1'b1;
        step(1);
        chk("R9", "no req after enable", irq_o, 1'b0);
        for (int k = 0; k < 8; k++) begin      // data bits: SDA moves only with SCL low
            set_lines(1'b0, 1'b0);
            set_lines(1'b0, k[0]);
            set_lines(1'b1, k[0]);
        end
        set_lines(1'b0, 1'b0);
        chk("R9", "no req during byte", irq_o, 1'b0);
        chk("R4", "still busy", bus_free, 1'b0);
        set_lines(1'b1, 1'b0);
        chk("R9", "no req at clock rise", irq_o, 1'b0);
        set_lines(1'b1, 1'b1);                 // stop
        chk("R9", "req at stop", irq_o, 1'b1);
        chk("R5", "free after stop", bus_free, 1'b1);
        irq_en = 1'b0; step(1);
        chk("R9", "req gated off", irq_o, 1'b0);

        // R6: disable clears and ignores events
        do_reset();
        set_lines(1'b1, 1'b0);
        chk("R6", "start before disable", start_seen, 1'b1);
        mon_en = 1'b0; step(1);
        chk("R6", "start cleared", start_seen, 1'b0);
        chk("R6", "flag cleared", irq_flag, 1'b0);
        set_lines(1'b1, 1'b1);                 // stop while disabled
        chk("R6", "stop ignored", stop_seen, 1'b0);
        set_lines(1'b1, 1'b0);                 // start while disabled
        chk("R6", "start ignored", start_seen, 1'b0);
        byte_done = 1'b1; step(1); byte_done = 1'b0;
        chk("R6", "byte ignored", irq_flag, 1'b0);
        chk("R6", "no pulse", evt_o, 1'b0);
        mon_en = 1'b1; step(1);
        chk("R6", "free after re-enable", bus_free, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule